// File: doc/BRIEF.md
# Register-Immediate Branch Resolution Unit

This unit resolves the sign-test branch group of a 32-bit load/store instruction set: the group picked out by a major opcode of `000001` whose second register field chooses the operation. Given the address of the branch, the instruction word and the value read for its source register, it works out where fetch goes next. It also says whether the next instruction sits in a delay slot or must be squashed, and whether a return address has to be written to the link register. Undefined encodings in the group raise a reserved-instruction indication instead.

All results are registered. The pipeline presents one instruction with a valid strobe in a cycle and reads the resolved outcome during the cycle after the next rising edge. When no branch of this group is accepted, the next-address register keeps its value and every pulse output is low. Fetch, the register file and exception handling sit outside the block.

Top module: `sign_branch_unit`

## Requirements
- R1: An instruction is accepted only when `in_valid` is 1 and bits 31:26 of `instr` equal `000001`. In the cycle after a cycle with no accepted instruction, `delay_slot`, `squash`, `link_we` and `resv_fault` are all 0.
- R2: Bits 20:16 of `instr` select the operation: 0x00 branch if negative, 0x01 branch if non-negative, 0x02 and 0x03 the same two tests in squashing form, 0x10 and 0x11 the same two tests with link.
- R3: The negative test is true exactly when bit 31 of `rs_val` is 1. The non-negative test is true exactly when that bit is 0.
- R4: A taken branch of any form sets `next_pc` to `pc + 4 + (sign-extended imm16 << 2)`, with `imm16` in bits 15:0, and sets `delay_slot` to 1 and `squash` to 0, one edge after acceptance.
- R5: A not-taken branch of the plain or link form sets `next_pc` to `pc + 8`, `delay_slot` to 1 and `squash` to 0.
- R6: A not-taken branch of the squashing form sets `next_pc` to `pc + 8`, `squash` to 1 and `delay_slot` to 0.
- R7: A link-form branch pulses `link_we` for exactly one cycle, taken or not, with `link_data = pc + 8` and `link_addr = 31`.
- R8: Any other value of bits 20:16 sets `resv_fault` for one cycle and leaves `next_pc` unchanged, with `link_we`, `delay_slot` and `squash` at 0.
- R9: All address sums wrap modulo 2^32 without any fault.
- R10: After reset, `next_pc` is 0 and `delay_slot`, `squash`, `link_we`, `resv_fault` and `link_data` are 0.
- R11: `next_pc` keeps its value in every cycle following one with no accepted, defined branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies pc, instr and rs_val this cycle |
| pc | input | 32 | Address of the branch instruction |
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value of the source register |
| next_pc | output | 32 | Resolved fetch address |
| delay_slot | output | 1 | Next instruction executes as a delay slot |
| squash | output | 1 | Delay-slot instruction is to be discarded |
| link_we | output | 1 | Write enable for the return address |
| link_addr | output | 5 | Register number for the return address |
| link_data | output | 32 | Return address |
| resv_fault | output | 1 | Reserved encoding in this group |

## Verification
Every result of the block appears on the first rising edge after its inputs are presented and stays there until the following edge. The pulse outputs fall again one edge later unless a new branch is accepted. The bench drives a vector on a falling edge, lets one rising edge pass, and compares all outputs at the next falling edge against a behavioural model that already holds the expected next address across idle and reserved cycles. Directed vectors cover each operation taken and not taken, all 26 reserved codes, wrong opcodes, a low strobe and wrap-around at both ends of the address space; seeded random vectors follow.

// File: rtl/sbu_pkg.sv
package sbu_pkg;

  localparam logic [5:0] GROUP_OPC = 6'b000001;

  // Decoded view of one instruction of the group
  typedef struct packed {
    logic hit;     // opcode matches the group
    logic resv;    // undefined selector value
    logic likely;  // squashing form
    logic link;    // return-address form
    logic on_neg;  // 1: test negative, 0: test non-negative
  } sbu_op_t;

endpackage

// File: rtl/sbu_decode.sv
module sbu_decode
  import sbu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] instr,
  output sbu_op_t         op
);
  logic [5:0] opc;
  logic [4:0] sel;

  assign opc = instr[31:26];
  assign sel = instr[20:16];

  always_comb begin
    op        = '0;
    op.hit    = (opc == GROUP_OPC);
    op.on_neg = ~sel[0];
    if (sel[4:2] == 3'b000) begin
      // plain (00,01) and squashing (10,11) forms
      op.likely = sel[1];
    end else if (sel[4:1] == 4'b1000) begin
      op.link = 1'b1;
    end else begin
      op.resv = 1'b1;
    end
  end
endmodule

// File: rtl/sbu_cond.sv
module sbu_cond #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] rs_val,
  input  logic            on_neg,
  output logic            taken
);
  logic neg;
  assign neg   = rs_val[XLEN-1];
  assign taken = on_neg ? neg : ~neg;
endmodule

// File: rtl/sbu_target.sv
module sbu_target #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  target,
  output logic [XLEN-1:0]  skip_pc
);
  localparam int OFF_W = IMM_W + 2;

  logic [XLEN-1:0] slot_pc;
  logic [XLEN-1:0] offset;

  generate
    if (XLEN > OFF_W) begin : g_sext
      assign offset = {{(XLEN-OFF_W){imm[IMM_W-1]}}, imm, 2'b00};
    end else begin : g_trunc
      assign offset = {imm[XLEN-3:0], 2'b00};
    end
  endgenerate

  // modulo 2^XLEN arithmetic, carries are dropped
  assign slot_pc = pc + XLEN'(4);
  assign target  = slot_pc + offset;
  assign skip_pc = slot_pc + XLEN'(4);
endmodule

// File: rtl/sign_branch_unit.sv
module sign_branch_unit
  import sbu_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          REG_AW   = 5,
  parameter int          LINK_REG = 31,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   instr,
  input  logic [XLEN-1:0]   rs_val,
  output logic [XLEN-1:0]   next_pc,
  output logic              delay_slot,
  output logic              squash,
  output logic              link_we,
  output logic [REG_AW-1:0] link_addr,
  output logic [XLEN-1:0]   link_data,
  output logic              resv_fault
);
  sbu_op_t         op;
  logic            taken;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] skip_pc;
  logic            accept;

  sbu_decode #(.XLEN(XLEN)) u_dec (
    .instr (instr),
    .op    (op)
  );

  sbu_cond #(.XLEN(XLEN)) u_cond (
    .rs_val (rs_val),
    .on_neg (op.on_neg),
    .taken  (taken)
  );

  sbu_target #(.XLEN(XLEN), .IMM_W(16)) u_tgt (
    .pc      (pc),
    .imm     (instr[15:0]),
    .target  (target),
    .skip_pc (skip_pc)
  );

  assign accept    = in_valid & op.hit;
  assign link_addr = REG_AW'(LINK_REG);

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc    <= XLEN'(RESET_PC);
      delay_slot <= 1'b0;
      squash     <= 1'b0;
      link_we    <= 1'b0;
      link_data  <= '0;
      resv_fault <= 1'b0;
    end else begin
      delay_slot <= 1'b0;
      squash     <= 1'b0;
      link_we    <= 1'b0;
      resv_fault <= 1'b0;
      if (accept) begin
        if (op.resv) begin
          resv_fault <= 1'b1;
        end else begin
          next_pc    <= taken ? target : skip_pc;
          delay_slot <= taken | ~op.likely;
          squash     <= op.likely & ~taken;
          if (op.link) begin
            link_we   <= 1'b1;
            link_data <= skip_pc;
          end
        end
      end
    end
  end

  // ---------------- assertions ----------------
  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !delay_slot && !squash && !link_we && !resv_fault);

  assert_link_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    accept && op.link && !op.resv |=> link_we && delay_slot && !squash);

  assert_link_addr_R7: assert property (@(posedge clk) disable iff (rst)
    link_we |-> link_addr == REG_AW'(LINK_REG));

  assert_squash_excl_R6: assert property (@(posedge clk) disable iff (rst)
    squash |-> !delay_slot && !link_we);

  assert_resv_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    resv_fault |-> !link_we && !delay_slot && !squash);

  assert_resv_hold_R8: assert property (@(posedge clk) disable iff (rst)
    accept && op.resv |=> $stable(next_pc));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(next_pc));
endmodule

// File: tb/test_sign_branch_unit.sv
module test_sign_branch_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] pc = '0, instr = '0, rs_val = '0;
  logic [31:0] next_pc, link_data;
  logic [4:0]  link_addr;
  logic        delay_slot, squash, link_we, resv_fault;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // expected state
  logic [31:0] e_pc = 32'h0;
  logic [31:0] e_ld = 32'h0;
  logic        e_ds, e_sq, e_we, e_rf;

  always #4 clk = ~clk; // 125 MHz

  sign_branch_unit i_sign_branch_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pc(pc), .instr(instr),
    .rs_val(rs_val), .next_pc(next_pc), .delay_slot(delay_slot),
    .squash(squash), .link_we(link_we), .link_addr(link_addr),
    .link_data(link_data), .resv_fault(resv_fault)
  );

  // behavioural reference
  task automatic model(input logic v, input logic [31:0] p,
                       input logic [31:0] ins, input logic [31:0] r);
    int code = int'(ins[20:16]);
    bit cond, lik, lnk, known;
    logic [31:0] off = {{14{ins[15]}}, ins[15:0], 2'b00};
    e_ds = 0; e_sq = 0; e_we = 0; e_rf = 0;
    if (!v || ins[31:26] != 6'd1) return;
    known = 1; lik = 0; lnk = 0;
    case (code)
      0, 1:    ;
      2, 3:    lik = 1;
      16, 17:  lnk = 1;
      default: known = 0;
    endcase
    if (!known) begin e_rf = 1; return; end
    cond = (code % 2 == 0) ? (r[31] == 1'b1) : (r[31] == 1'b0);
    if (cond) begin
      e_pc = p + 32'd4 + off; e_ds = 1;
    end else begin
      e_pc = p + 32'd8;
      if (lik) e_sq = 1; else e_ds = 1;
    end
    if (lnk) begin e_we = 1; e_ld = p + 32'd8; end
  endtask

  task automatic compare(input string tag);
    bit ok;
    n_vec++;
    ok = (next_pc == e_pc) && (delay_slot == e_ds) && (squash == e_sq) &&
         (link_we == e_we) && (resv_fault == e_rf) && (link_data == e_ld) &&
         (!e_we || link_addr == 5'd31);
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got pc=%h ds=%b sq=%b we=%b la=%0d ld=%h rf=%b exp pc=%h ds=%b sq=%b we=%b la=31 ld=%h rf=%b",
               tag, next_pc, delay_slot, squash, link_we, link_addr, link_data,
               resv_fault, e_pc, e_ds, e_sq, e_we, e_ld, e_rf);
    end
  endtask

  // entered and left at a falling edge
  task automatic apply(input logic v, input logic [31:0] p,
                       input logic [31:0] ins, input logic [31:0] r,
                       input string tag);
    in_valid = v; pc = p; instr = ins; rs_val = r;
    model(v, p, ins, r);
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] sel,
                                     input logic [15:0] imm);
    return {opc, 5'd7, sel, imm};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] neg = 32'h8000_0005;
    logic [31:0] pos = 32'h0000_1234;
    repeat (3) @(negedge clk);
    rst = 0;
    e_ds = 0; e_sq = 0; e_we = 0; e_rf = 0;
    compare("R10 reset state");
    // R2/R3/R4/R5: plain forms
    apply(1, 32'h0000_1000, mk(6'd1, 5'h00, 16'h0010), neg, "R4 neg taken");
    apply(1, 32'h0000_1000, mk(6'd1, 5'h00, 16'h0010), pos, "R5 neg not taken");
    apply(1, 32'h0000_2000, mk(6'd1, 5'h01, 16'hFFF0), pos, "R3 nonneg taken back");
    apply(1, 32'h0000_2000, mk(6'd1, 5'h01, 16'hFFF0), neg, "R3 nonneg not taken");
    apply(1, 32'h0000_2000, mk(6'd1, 5'h01, 16'h0004), 32'h0, "R3 zero is nonneg");
    // R6: squashing forms
    apply(1, 32'h0000_3000, mk(6'd1, 5'h02, 16'h0020), neg, "R6 neg-sq taken");
    apply(1, 32'h0000_3000, mk(6'd1, 5'h02, 16'h0020), pos, "R6 neg-sq squash");
    apply(1, 32'h0000_3100, mk(6'd1, 5'h03, 16'h0020), pos, "R6 nonneg-sq taken");
    apply(1, 32'h0000_3100, mk(6'd1, 5'h03, 16'h0020), neg, "R6 nonneg-sq squash");
    // R7: link forms
    apply(1, 32'h0000_4000, mk(6'd1, 5'h10, 16'h0100), neg, "R7 neg-link taken");
    apply(1, 32'h0000_4010, mk(6'd1, 5'h10, 16'h0100), pos, "R7 neg-link not taken");
    apply(1, 32'h0000_4020, mk(6'd1, 5'h11, 16'h8000), pos, "R7 nonneg-link taken");
    apply(1, 32'h0000_4030, mk(6'd1, 5'h11, 16'h8000), neg, "R7 nonneg-link not taken");
    apply(0, 32'h0000_4040, mk(6'd1, 5'h11, 16'h0000), pos, "R7 single pulse");
    // R8: every reserved selector
    for (int s = 0; s < 32; s++) begin
      if (!(s < 4 || s == 16 || s == 17))
        apply(1, 32'h0000_5000 + 32'(s), mk(6'd1, 5'(s), 16'h0044), neg, "R8 reserved");
    end
    // R1/R11: strobe low, wrong opcodes
    apply(0, 32'h0000_6000, mk(6'd1, 5'h00, 16'h0001), neg, "R1 strobe low");
    apply(1, 32'h0000_6000, mk(6'd0, 5'h00, 16'h0001), neg, "R1 opcode 0");
    apply(1, 32'h0000_6000, mk(6'd3, 5'h10, 16'h0001), neg, "R11 opcode 3 hold");
    apply(1, 32'h0000_6000, mk(6'h21, 5'h01, 16'h0001), pos, "R11 opcode 21 hold");
    // R9: wrap-around
    apply(1, 32'hFFFF_FFFC, mk(6'd1, 5'h10, 16'h0004), neg, "R9 wrap up link");
    apply(1, 32'h0000_0000, mk(6'd1, 5'h01, 16'hFFF0), pos, "R9 wrap down");
    apply(1, 32'hFFFF_FFF8, mk(6'd1, 5'h03, 16'h0000), neg, "R9 wrap skip");
    // reset in mid-stream
    rst = 1; in_valid = 1; instr = mk(6'd1, 5'h10, 16'h0001);
    @(negedge clk);
    rst = 0; e_pc = 0; e_ld = 0; e_ds = 0; e_sq = 0; e_we = 0; e_rf = 0;
    compare("R10 reset again");
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [31:0] w = $urandom;
      logic [5:0]  o = ($urandom % 4 != 0) ? 6'd1 : 6'($urandom);
      logic [4:0]  sl;
      case ($urandom % 8)
        0: sl = 5'h00; 1: sl = 5'h01; 2: sl = 5'h02; 3: sl = 5'h03;
        4: sl = 5'h10; 5: sl = 5'h11; default: sl = 5'($urandom);
      endcase
      apply(1'($urandom % 5 != 0), $urandom, {o, w[25:21], sl, w[15:0]},
            $urandom, "R2 random");
    end
    finish_run();
  end
endmodule